// File: doc/BRIEF.md
# MSI Capability Register Block

This block holds the configuration-space registers of a message-signalled-interrupt capability for one PCI function. Configuration software reaches it through dword-wide reads and writes, with a byte enable for each byte, addressed by the dword index into the function's 256-byte configuration space. The block keeps the following state:

- the control word;
- the message address, either 32-bit or 64-bit;
- the 16-bit message data;
- optionally, a per-vector mask register and a pending register.

It presents all of this state on ports so that a separate message generator can use it.

Parameters fix the variant at build time: the byte offset of the capability, whether the address is 64-bit, whether per-vector masking exists, and the log2 of the advertised vector count. The message generator records masked vectors by setting and clearing bits of the pending register through a side port. While the enable bit is set, the block drives a signal that tells the function to withdraw any legacy INTx request.

Top module: `msi_cap_regs`

## Requirements
- R1: Reset clears the multiple-message-enable field, the enable bit, both address halves, the data, the mask and the pending register. A read of the control dword after reset returns only the fixed fields.
- R2: The control word occupies bits [31:16] of the capability's first dword. Its layout is:
  - bit 16: enable;
  - bits [19:17]: log2 of the vectors capable;
  - bits [22:20]: log2 of the vectors enabled;
  - bit 23: 64-bit flag;
  - bit 24: mask-capable flag.
  Only the enable bit and the enabled-count field accept writes. A write reaches them only when byte enable 2 is set.
- R3: When a write to the enabled-count field exceeds the capable value, the stored value becomes the capable value.
- R4: The low address dword sits at relative offset 0x04, and its bits [1:0] always read as zero. In the 64-bit variant the high address dword sits at 0x08. Together they drive `msg_addr`.
- R5: The message data is 16 bits wide, in bits [15:0] of the dword at 0x08 (32-bit variant) or 0x0C (64-bit variant). Its upper bits read as zero.
- R6: The mask register sits one dword below the pending register. Only bits 0 to N-1 accept writes, where N is the advertised vector count. Higher bits read as zero.
- R7: The pending register sits at 0x10 (32-bit variant) or 0x14 (64-bit variant) and ignores configuration writes. A bit of `pend_set` sets the matching pending bit one cycle later, and a bit of `pend_clr` clears it. When both are set for the same bit, set wins. Bits N and above stay zero.
- R8: `intx_off` is high exactly while the enable bit is set.
- R9: The block ignores writes that fall outside the capability window, whose length is 0x0A, 0x0E, 0x14 or 0x18 bytes depending on the variant. Inside the window, only the bytes whose enables are set change.
- R10: A read returns its data with `cfg_rvalid` one cycle after `cfg_rd`. Addresses outside the window, and bits with no field behind them, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Dword index into configuration space |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data |
| cfg_rvalid | output | 1 | Read data valid |
| pend_set | input | 32 | Pending-bit set requests from the message generator |
| pend_clr | input | 32 | Pending-bit clear requests from the message generator |
| msi_en | output | 1 | Enable bit |
| msg_en_log2 | output | 3 | Stored log2 of enabled vectors |
| msg_addr | output | 64 | Message address |
| msg_data | output | 16 | Message data |
| vec_mask | output | 32 | Per-vector mask |
| vec_pend | output | 32 | Per-vector pending |
| intx_off | output | 1 | Withdraw legacy INTx request |

## Verification
The assertions check, on every cycle:
- the enabled-count field never exceeds the capable value;
- the low address bits stay zero;
- mask and pending bits stay inside the advertised vector range;
- the pending register changes only when the side port asks it to;
- the enable bit rises only on a control write;
- the stored fields hold still whenever no write hits the window.

The exact register layout of each field, the byte-enable merging, the read-back values of fixed and unimplemented bits, and the clearing of registers by a reset in the middle of a run can only be shown by the bench's read-back scenarios.

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter int unsigned CAP_BASE = 8'h50,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          PVM      = 1'b1,
  parameter int unsigned LOG2_VEC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [3:0]  cfg_be,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid,
  input  logic [31:0] pend_set,
  input  logic [31:0] pend_clr,
  output logic        msi_en,
  output logic [2:0]  msg_en_log2,
  output logic [63:0] msg_addr,
  output logic [15:0] msg_data,
  output logic [31:0] vec_mask,
  output logic [31:0] vec_pend,
  output logic        intx_off
);

  localparam int unsigned NVEC    = 1 << LOG2_VEC;
  localparam logic [31:0] VMASK   = 32'hFFFF_FFFF >> (32 - NVEC);
  localparam logic [2:0]  MMC     = 3'(LOG2_VEC);
  localparam int unsigned CAP_LEN = ADDR64 ? (PVM ? 24 : 14) : (PVM ? 20 : 10);
  localparam logic [5:0]  CAP_DW  = 6'(CAP_BASE >> 2);
  localparam logic [5:0]  WIN_DW  = 6'((CAP_LEN + 3) / 4);
  localparam logic [5:0]  DW_DATA = ADDR64 ? 6'd3 : 6'd2;
  localparam logic [5:0]  DW_MASK = DW_DATA + 6'd1;
  localparam logic [5:0]  DW_PEND = DW_DATA + 6'd2;

  logic [5:0]  rel;
  logic        in_win, wr_hit, wr_ctrl;
  logic [2:0]  mme_req, mme_next;
  logic [31:0] merged;
  logic [31:0] addr_lo, addr_hi;
  logic [15:0] data_q;
  logic [31:0] mask_q, pend_q;
  logic [31:0] rd_mux;
  logic [15:0] ctrl_word;

  assign rel     = cfg_addr - CAP_DW;
  assign in_win  = (cfg_addr >= CAP_DW) && (rel < WIN_DW);
  assign wr_hit  = cfg_wr && in_win;
  assign wr_ctrl = wr_hit && (rel == 6'd0) && cfg_be[2];

  assign mme_req  = cfg_wdata[22:20];
  assign mme_next = (mme_req > MMC) ? MMC : mme_req;

  always_comb begin
    unique case (rel)
      6'd1:    merged = addr_lo;
      6'd2:    merged = ADDR64 ? addr_hi : {16'h0, data_q};
      DW_DATA: merged = {16'h0, data_q};
      DW_MASK: merged = mask_q;
      default: merged = 32'h0;
    endcase
    for (int b = 0; b < 4; b++)
      if (cfg_be[b]) merged[8*b +: 8] = cfg_wdata[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en      <= 1'b0;
      msg_en_log2 <= 3'd0;
    end else if (wr_ctrl) begin
      msi_en      <= cfg_wdata[16];
      msg_en_log2 <= mme_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_lo <= 32'h0;
    else if (wr_hit && rel == 6'd1) addr_lo <= {merged[31:2], 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= 16'h0;
    else if (wr_hit && rel == DW_DATA) data_q <= merged[15:0];
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_hi <= 32'h0;
        else if (wr_hit && rel == 6'd2) addr_hi <= merged;
      end
    end else begin : g_nohi
      assign addr_hi = 32'h0;
    end

    if (PVM) begin : g_pvm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= 32'h0;
        else if (wr_hit && rel == DW_MASK) mask_q <= merged & VMASK;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 32'h0;
        else pend_q <= ((pend_q & ~pend_clr) | pend_set) & VMASK;
      end
    end else begin : g_nopvm
      assign mask_q = 32'h0;
      assign pend_q = 32'h0;
    end
  endgenerate

  assign ctrl_word = {7'h0, PVM, ADDR64, msg_en_log2, MMC, msi_en};

  always_comb begin
    rd_mux = 32'h0;
    if (in_win) begin
      if (rel == 6'd0)                   rd_mux = {ctrl_word, 16'h0};
      else if (rel == 6'd1)              rd_mux = addr_lo;
      else if (ADDR64 && rel == 6'd2)    rd_mux = addr_hi;
      else if (rel == DW_DATA)           rd_mux = {16'h0, data_q};
      else if (PVM && rel == DW_MASK)    rd_mux = mask_q;
      else if (PVM && rel == DW_PEND)    rd_mux = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= 32'h0;
    end else begin
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= cfg_rd ? rd_mux : 32'h0;
    end
  end

  assign msg_addr = {addr_hi, addr_lo};
  assign msg_data = data_q;
  assign vec_mask = mask_q;
  assign vec_pend = pend_q;
  assign intx_off = msi_en;

  assert_mme_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_en_log2 <= MMC);

  assert_addr_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_addr[1:0] == 2'b00);

  assert_mask_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mask & ~VMASK) == 32'h0);

  assert_pend_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_pend & ~VMASK) == 32'h0);

  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (PVM && ((pend_set & VMASK) != 32'h0)) |=>
      ((vec_pend & $past(pend_set & VMASK)) == $past(pend_set & VMASK)));

  assert_pend_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set == 32'h0 && pend_clr == 32'h0) |=> $stable(vec_pend));

  assert_en_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_en) |-> $past(wr_ctrl && cfg_wdata[16]));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(msg_addr) && $stable(msg_data) && $stable(vec_mask)
                 && $stable(msi_en) && $stable(msg_en_log2)));

  assert_intx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msi_en) |-> !intx_off);

endmodule

// File: tb/sim_msi_cap_regs.sv
module sim_msi_cap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = 6'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [31:0] pend_set = 32'h0, pend_clr = 32'h0;
  logic        msi_en, intx_off;
  logic [2:0]  msg_en_log2;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;
  logic [31:0] vec_mask, vec_pend;

  int total = 0, bad = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  localparam logic [5:0] A_CTRL = 6'h14, A_ALO = 6'h15, A_AHI = 6'h16,
                         A_DATA = 6'h17, A_MASK = 6'h18, A_PEND = 6'h19,
                         A_AFTER = 6'h1A, A_BEFORE = 6'h13;

  always #5 clk = ~clk;

  msi_cap_regs u0 (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic pend_pulse(input logic [31:0] s, input logic [31:0] c);
    @(negedge clk);
    pend_set = s; pend_clr = c;
    @(negedge clk);
    pend_set = 32'h0; pend_clr = 32'h0;
  endtask

  always @(negedge clk) begin
    if (cfg_rvalid) begin
      if (q_exp.size() == 0) chk(64'(cfg_rdata), 64'hX, "R10 unexpected read data");
      else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(64'(cfg_rdata), 64'(e), t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(64'(msi_en), 64'd0, "R1 enable after reset");
    chk(64'(intx_off), 64'd0, "R8 intx_off after reset");
    chk(msg_addr, 64'd0, "R1 address after reset");
    chk(64'(vec_mask), 64'd0, "R1 mask after reset");
    rd(A_CTRL, 32'h0186_0000, "R1 control fixed fields");
    rd(A_ALO, 32'h0, "R1 addr lo reset");
    rd(A_PEND, 32'h0, "R1 pending reset");

    wr(A_CTRL, 32'h0071_0000, 4'b1100);
    rd(A_CTRL, 32'h01B7_0000, "R3 clamp enabled count");
    chk(64'(msg_en_log2), 64'd3, "R3 clamp port");
    chk(64'(intx_off), 64'd1, "R8 intx_off while enabled");

    wr(A_CTRL, 32'h0020_0000, 4'b1100);
    rd(A_CTRL, 32'h01A6_0000, "R2 count 2 disabled");
    chk(64'(intx_off), 64'd0, "R8 intx_off released");

    wr(A_CTRL, 32'hFFFE_0000, 4'b1111);
    rd(A_CTRL, 32'h01B6_0000, "R2 fixed fields hold");
    wr(A_CTRL, 32'h0031_0000, 4'b0011);
    rd(A_CTRL, 32'h01B6_0000, "R9 control needs byte enable 2");

    wr(A_ALO, 32'hDEAD_BEEF, 4'b1111);
    rd(A_ALO, 32'hDEAD_BEEC, "R4 low bits zero");
    wr(A_ALO, 32'h1122_3344, 4'b0011);
    rd(A_ALO, 32'hDEAD_3344, "R9 byte enables");
    wr(A_AHI, 32'h1234_5678, 4'b1111);
    rd(A_AHI, 32'h1234_5678, "R4 addr hi");
    chk(msg_addr, 64'h1234_5678_DEAD_3344, "R4 msg_addr port");

    wr(A_DATA, 32'hABCD_1234, 4'b1111);
    rd(A_DATA, 32'h0000_1234, "R5 data 16 bits");
    chk(64'(msg_data), 64'h1234, "R5 msg_data port");

    wr(A_MASK, 32'hFFFF_FFFF, 4'b1111);
    rd(A_MASK, 32'h0000_00FF, "R6 mask range");
    wr(A_MASK, 32'h0000_00A5, 4'b0001);
    rd(A_MASK, 32'h0000_00A5, "R6 mask write");

    wr(A_PEND, 32'hFFFF_FFFF, 4'b1111);
    rd(A_PEND, 32'h0, "R7 pending ignores config write");
    pend_pulse(32'h0000_0105, 32'h0);
    rd(A_PEND, 32'h0000_0005, "R7 set in range only");
    chk(64'(vec_pend), 64'h5, "R7 vec_pend port");
    pend_pulse(32'h1, 32'h1);
    rd(A_PEND, 32'h0000_0005, "R7 set wins");
    pend_pulse(32'h0, 32'h4);
    rd(A_PEND, 32'h0000_0001, "R7 clear");

    wr(A_AFTER, 32'hFFFF_FFFF, 4'b1111);
    wr(A_BEFORE, 32'hFFFF_FFFF, 4'b1111);
    rd(A_CTRL, 32'h01B6_0000, "R9 ctrl untouched");
    rd(A_ALO, 32'hDEAD_3344, "R9 addr lo untouched");
    rd(A_AHI, 32'h1234_5678, "R9 addr hi untouched");
    rd(A_DATA, 32'h0000_1234, "R9 data untouched");
    rd(A_MASK, 32'h0000_00A5, "R9 mask untouched");
    rd(A_AFTER, 32'h0, "R10 past window reads zero");
    rd(A_BEFORE, 32'h0, "R10 before window reads zero");
    rd(6'h00, 32'h0, "R10 far address reads zero");

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_CTRL, 32'h0186_0000, "R1 ctrl after midrun reset");
    rd(A_ALO, 32'h0, "R1 addr lo cleared");
    rd(A_AHI, 32'h0, "R1 addr hi cleared");
    rd(A_DATA, 32'h0, "R1 data cleared");
    rd(A_MASK, 32'h0, "R1 mask cleared");
    rd(A_PEND, 32'h0, "R1 pending cleared");

    repeat (3) @(negedge clk);
    chk(64'(q_exp.size()), 64'd0, "R10 every read answered");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule